// File: doc/BRIEF.md
# Recursive Butterfly Packet Crossbar

This block is an N-by-N unicast packet switch, where N is a power of two set by the parameter `LOGN`. Every input port takes one data word per cycle through a valid/ready handshake. A combinational destination function maps each word to a 32-bit destination value, and the low `LOGN` bits of that value name the output port. Every output port hands words on through its own valid/ready handshake.

The structure follows the recursive butterfly. The smallest switch is a single queue between one input and one output. A switch of size 2M is two switches of size M side by side, followed by a column of 2M two-input merge units. In the stage that builds size 2^(s+1), destination bit s decides the path. A word whose bit s already equals bit s of its current position goes on the first input of the merge unit at that position. Otherwise it goes on the second input of the merge unit whose index has bit s flipped. Each merge unit has its own small queue and its own round-robin arbiter, and it withdraws ready when its queue is full. Backpressure therefore travels stage by stage back to the input ports, and no word is ever dropped.

Top module: `xbar_top`

## Requirements
- R1: After reset every `out_valid` bit is low and every `in_ready` bit is high.
- R2: A word leaves on the output port whose index equals the low `LOGN` bits of its destination value. The destination value is the word zero-extended to 32 bits, so the port is word bits [LOGN-1:0].
- R3: Every accepted word is delivered exactly once, and no word is lost while any ready is low. No more than N*DEPTH*(LOGN+1) words are ever in flight.
- R4: Words that travel from one input port to one output port leave in the order they were accepted.
- R5: While `out_valid[p]` is high and `out_ready[p]` is low, on the next cycle `out_valid[p]` stays high and `out_data[p]` is unchanged.
- R6: In an empty switch with all outputs ready, a word accepted at a clock edge is presented on its output after exactly LOGN further clock edges.
- R7: When two inputs compete continuously for the same merge unit, it serves them in strict alternation, so the output carries one word per cycle with the two sources interleaved.
- R8: With one output held not ready and a single flow aimed at it, the input accepts exactly DEPTH*(LOGN+1) words. After that its `in_ready` stays low until the output is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N | A word is offered on each input port |
| in_ready | output | N | Each input port can take a word |
| in_data | input | N*DW | Input words, one DW-bit word per port |
| out_valid | output | N | A word is offered on each output port |
| out_ready | input | N | The consumer takes the word on each output port |
| out_data | output | N*DW | Output words, one DW-bit word per port |

## Verification
Every queue is registered, so a word accepted at an input edge reaches the first merge column's queue at the next edge. It moves one column further at each edge after that and is presented on its output LOGN edges after acceptance. The latency check samples the output on the falling edge after each of those edges and expects it to be low until the last one.

The bench drives its inputs just after a rising edge and reads handshakes on the falling edge, which is the value the next rising edge will use. Accepted words are queued per flow, and each delivery is compared with the head of its flow queue in the same half cycle.

The capacity count (R8) is read on that same falling edge, and so is the hold check (R5), which compares each output against the value it had one cycle earlier.

// File: rtl/xbar_pkg.sv
package xbar_pkg;

    typedef logic [31:0] xbar_dest_t;

    // Destination function: maps a word (zero-extended to 32 bits) to its
    // 32-bit destination value. The low LOGN bits select the output port.
    function automatic xbar_dest_t xbar_dest(input logic [31:0] word);
        return word;
    endfunction

    // Routing bit examined by the stage that builds switches of size 2^(idx+1).
    function automatic logic xbar_dest_bit(input logic [31:0] word, input int idx);
        xbar_dest_t d;
        d = xbar_dest(word);
        return d[idx];
    endfunction

endpackage

// File: rtl/xbar_fifo.sv
module xbar_fifo #(
    parameter int DW    = 16,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_valid,
    input  logic [DW-1:0] push_data,
    output logic          push_ready,
    output logic          pop_valid,
    output logic [DW-1:0] pop_data,
    input  logic          pop_ready
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = AW + 1;

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [AW-1:0]            wp;
        logic [AW-1:0]            rp;
        logic [CW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_q, st_d;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] ptr);
        return (ptr == AW'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    endfunction

    assign push_ready = (st_q.cnt != CW'(DEPTH));
    assign pop_valid  = (st_q.cnt != '0);
    assign pop_data   = st_q.mem[st_q.rp];

    always_comb begin
        logic do_push;
        logic do_pop;
        st_d    = st_q;
        do_push = push_valid && push_ready;
        do_pop  = pop_valid && pop_ready;
        if (do_push) begin
            st_d.mem[st_q.wp] = push_data;
            st_d.wp           = ptr_inc(st_q.wp);
        end
        if (do_pop) begin
            st_d.rp = ptr_inc(st_q.rp);
        end
        case ({do_push, do_pop})
            2'b10:   st_d.cnt = st_q.cnt + 1'b1;
            2'b01:   st_d.cnt = st_q.cnt - 1'b1;
            default: st_d.cnt = st_q.cnt;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/xbar_merge2.sv
module xbar_merge2 #(
    parameter int DW    = 16,
    parameter int DEPTH = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          a_valid,
    input  logic [DW-1:0] a_data,
    output logic          a_ready,
    input  logic          b_valid,
    input  logic [DW-1:0] b_data,
    output logic          b_ready,
    output logic          o_valid,
    output logic [DW-1:0] o_data,
    input  logic          o_ready
);
    typedef struct packed {
        logic favor_b;
    } arb_st_t;

    arb_st_t       st_q, st_d;
    logic          sel_b;
    logic          q_ready;
    logic          q_valid;
    logic [DW-1:0] q_data;

    always_comb begin
        st_d    = st_q;
        sel_b   = b_valid && (!a_valid || st_q.favor_b);
        q_valid = a_valid || b_valid;
        q_data  = sel_b ? b_data : a_data;
        a_ready = q_ready && !sel_b;
        b_ready = q_ready && sel_b;
        if (q_valid && q_ready) begin
            st_d.favor_b = !sel_b;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    xbar_fifo #(.DW(DW), .DEPTH(DEPTH)) queue_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_valid (q_valid),
        .push_data  (q_data),
        .push_ready (q_ready),
        .pop_valid  (o_valid),
        .pop_data   (o_data),
        .pop_ready  (o_ready)
    );
endmodule

// File: rtl/xbar_top.sv
module xbar_top #(
    parameter int LOGN  = 2,
    parameter int DW    = 16,
    parameter int DEPTH = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [(1<<LOGN)-1:0]          in_valid,
    output logic [(1<<LOGN)-1:0]          in_ready,
    input  logic [(1<<LOGN)-1:0][DW-1:0]  in_data,
    output logic [(1<<LOGN)-1:0]          out_valid,
    input  logic [(1<<LOGN)-1:0]          out_ready,
    output logic [(1<<LOGN)-1:0][DW-1:0]  out_data
);
    localparam int N = 1 << LOGN;

    // Column c carries the words leaving column c (0 = input queues).
    logic          lv [LOGN+1][N];
    logic          lr [LOGN+1][N];
    logic [DW-1:0] ld [LOGN+1][N];

    // Base case: one queue per port.
    for (genvar p = 0; p < N; p++) begin : g_base
        xbar_fifo #(.DW(DW), .DEPTH(DEPTH)) base_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .push_valid (in_valid[p]),
            .push_data  (in_data[p]),
            .push_ready (in_ready[p]),
            .pop_valid  (lv[0][p]),
            .pop_data   (ld[0][p]),
            .pop_ready  (lr[0][p])
        );
    end

    // Recursive step, unrolled: stage s merges pairs of size-2^s switches.
    for (genvar s = 0; s < LOGN; s++) begin : g_stage
        localparam int HALF = 1 << s;
        logic a_rdy [N];
        logic b_rdy [N];

        for (genvar p = 0; p < N; p++) begin : g_pos
            localparam int  PEER  = p ^ HALF;
            localparam logic P_BIT = logic'((p >> s) & 1);
            logic self_moves;
            logic peer_moves;

            assign self_moves = xbar_pkg::xbar_dest_bit(32'(ld[s][p]), s) != P_BIT;
            assign peer_moves = xbar_pkg::xbar_dest_bit(32'(ld[s][PEER]), s) == P_BIT;
            assign lr[s][p]   = self_moves ? b_rdy[PEER] : a_rdy[p];

            xbar_merge2 #(.DW(DW), .DEPTH(DEPTH)) merge_i (
                .clk     (clk),
                .rst_n   (rst_n),
                .a_valid (lv[s][p] && !self_moves),
                .a_data  (ld[s][p]),
                .a_ready (a_rdy[p]),
                .b_valid (lv[s][PEER] && peer_moves),
                .b_data  (ld[s][PEER]),
                .b_ready (b_rdy[p]),
                .o_valid (lv[s+1][p]),
                .o_data  (ld[s+1][p]),
                .o_ready (lr[s+1][p])
            );
        end
    end

    for (genvar p = 0; p < N; p++) begin : g_out
        assign out_valid[p] = lv[LOGN][p];
        assign out_data[p]  = ld[LOGN][p];
        assign lr[LOGN][p]  = out_ready[p];
    end
endmodule

// File: rtl/xbar_checker.sv
module xbar_checker #(
    parameter int LOGN  = 2,
    parameter int DW    = 16,
    parameter int DEPTH = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [(1<<LOGN)-1:0]         in_valid,
    input logic [(1<<LOGN)-1:0]         in_ready,
    input logic [(1<<LOGN)-1:0]         out_valid,
    input logic [(1<<LOGN)-1:0]         out_ready,
    input logic [(1<<LOGN)-1:0][DW-1:0] out_data
);
    localparam int N    = 1 << LOGN;
    localparam int CAP  = N * DEPTH * (LOGN + 1);

    int inflight_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) inflight_q <= 0;
        else        inflight_q <= inflight_q + $countones(in_valid & in_ready)
                                             - $countones(out_valid & out_ready);
    end

    // R3: storage bound on words between the ports
    p_capacity_r3: assert property (@(posedge clk) disable iff (!rst_n)
        inflight_q <= CAP);

    // R3: nothing is presented that was never accepted
    p_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (|out_valid) |-> (inflight_q >= $countones(out_valid)));

    for (genvar p = 0; p < N; p++) begin : g_port
        // R5: a stalled output word is held
        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            (out_valid[p] && !out_ready[p]) |=> (out_valid[p] && $stable(out_data[p])));

        // R2: the word's destination matches its port
        p_route_r2: assert property (@(posedge clk) disable iff (!rst_n)
            out_valid[p] |-> ((xbar_pkg::xbar_dest(32'(out_data[p])) & 32'(N - 1)) == 32'(p)));
    end
endmodule

bind xbar_top xbar_checker #(.LOGN(LOGN), .DW(DW), .DEPTH(DEPTH)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data)
);

// File: tb/xbar_top_tb_top.sv
module xbar_top_tb_top;
    localparam int LOGN  = 2;
    localparam int DW    = 16;
    localparam int DEPTH = 2;
    localparam int N     = 1 << LOGN;
    localparam int SW    = DW - 2 * LOGN;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic [N-1:0]         in_valid, in_ready, out_valid, out_ready;
    logic [N-1:0][DW-1:0] in_data, out_data;

    xbar_top #(.LOGN(LOGN), .DW(DW), .DEPTH(DEPTH)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
    );

    int n_checks = 0;
    int n_errs   = 0;
    bit finished = 1'b0;

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_errs++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // stimulus controls
    bit           feed_en   [N];
    int           feed_dest [N];
    int           seqn      [N];
    bit           acc_seen  [N];
    bit           rand_mode = 1'b0;
    logic [N-1:0] fixed_ready = '0;
    bit           rr_watch = 1'b0;
    int           rr_log [$];

    // reference model: accepted words per flow (src*N + dst)
    logic [DW-1:0] expq [N*N][$];
    bit            hold_prev [N];
    logic [DW-1:0] hold_data [N];

    // driver: changes inputs 1 ns after the rising edge
    initial begin
        in_valid  = '0;
        in_data   = '0;
        out_ready = '0;
        for (int i = 0; i < N; i++) begin
            feed_en[i] = 1'b0; feed_dest[i] = 0; seqn[i] = 0; acc_seen[i] = 1'b0;
        end
        forever begin
            @(posedge clk);
            #1;
            for (int i = 0; i < N; i++) begin
                if (!in_valid[i] || acc_seen[i]) begin
                    if (feed_en[i] && !(rand_mode && $urandom_range(3) == 0)) begin
                        int dst;
                        dst = (feed_dest[i] < 0) ? int'($urandom_range(N - 1)) : feed_dest[i];
                        in_data[i]  = {SW'(seqn[i]), LOGN'(i), LOGN'(dst)};
                        seqn[i]++;
                        in_valid[i] = 1'b1;
                    end else begin
                        in_valid[i] = 1'b0;
                    end
                end
            end
            for (int p = 0; p < N; p++)
                out_ready[p] = rand_mode ? ($urandom_range(2) != 0) : fixed_ready[p];
        end
    end

    // monitor: reads handshakes on the falling edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            for (int i = 0; i < N; i++) begin
                acc_seen[i] = in_valid[i] && in_ready[i];
                if (acc_seen[i])
                    expq[i*N + int'(in_data[i][LOGN-1:0])].push_back(in_data[i]);
            end
            for (int p = 0; p < N; p++) begin
                if (hold_prev[p])
                    check(out_valid[p] && (out_data[p] == hold_data[p]), "R5", "held word",
                          longint'(out_data[p]), longint'(hold_data[p]));
                if (out_valid[p] && out_ready[p]) begin
                    int dst, src, f;
                    dst = int'(out_data[p][LOGN-1:0]);
                    src = int'(out_data[p][2*LOGN-1:LOGN]);
                    f   = src * N + p;
                    check(dst == p, "R2", "port of word", dst, p);
                    if (expq[f].size() == 0) begin
                        check(1'b0, "R3", "unexpected word", longint'(out_data[p]), -1);
                    end else begin
                        logic [DW-1:0] e;
                        e = expq[f].pop_front();
                        check(e == out_data[p], "R4", "flow order", longint'(out_data[p]), longint'(e));
                    end
                    if (rr_watch && p == 0) rr_log.push_back(src);
                end
                hold_prev[p] = out_valid[p] && !out_ready[p];
                hold_data[p] = out_data[p];
            end
        end
    end

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
    endtask

    // watchdog
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_errs++;
            $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
            report();
            $finish;
        end
    end

    initial begin
        for (int p = 0; p < N; p++) begin hold_prev[p] = 1'b0; hold_data[p] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        fixed_ready = '1;
        @(negedge clk);
        // R1: idle after reset
        check(out_valid == '0, "R1", "out_valid", longint'(out_valid), 0);
        check(in_ready == '1, "R1", "in_ready", longint'(in_ready), longint'((1 << N) - 1));

        // R6: latency through an empty switch
        feed_dest[0] = N - 1;
        feed_en[0]   = 1'b1;
        @(negedge clk);
        feed_en[0]   = 1'b0;
        for (int k = 0; k <= LOGN; k++) begin
            @(negedge clk);
            check(out_valid[N-1] == (k == LOGN), "R6", "out_valid after edges",
                  longint'(out_valid[N-1]), longint'(k == LOGN));
        end
        repeat (5) @(negedge clk);

        // R8: single stalled flow fills its path
        begin
            int cnt;
            cnt = 0;
            fixed_ready[1] = 1'b0;
            feed_dest[1]   = 1;
            feed_en[1]     = 1'b1;
            for (int t = 0; t < 200; t++) begin
                @(negedge clk);
                if (in_valid[1] && in_ready[1]) cnt++;
                else if (in_valid[1] && !in_ready[1]) break;
            end
            check(cnt == DEPTH * (LOGN + 1), "R8", "words accepted before stall",
                  cnt, DEPTH * (LOGN + 1));
            repeat (4) begin
                @(negedge clk);
                check(!in_ready[1] && out_valid[1], "R8", "stall holds (ready,valid)",
                      longint'({in_ready[1], out_valid[1]}), 1);
            end
            feed_en[1]     = 1'b0;
            fixed_ready[1] = 1'b1;
            repeat (30) @(negedge clk);
        end

        // R7: two sources contending for output 0
        feed_dest[0] = 0; feed_dest[1] = 0;
        feed_en[0] = 1'b1; feed_en[1] = 1'b1;
        repeat (12) @(negedge clk);
        rr_watch = 1'b1;
        repeat (40) @(negedge clk);
        rr_watch = 1'b0;
        feed_en[0] = 1'b0; feed_en[1] = 1'b0;
        repeat (30) @(negedge clk);
        check(rr_log.size() >= 38, "R7", "words in window", rr_log.size(), 40);
        for (int k = 1; k < rr_log.size(); k++)
            check(rr_log[k] != rr_log[k-1], "R7", "alternating source", rr_log[k], 1 - rr_log[k-1]);

        // R3/R4: random traffic with random backpressure
        for (int i = 0; i < N; i++) begin feed_dest[i] = -1; feed_en[i] = 1'b1; end
        rand_mode = 1'b1;
        repeat (3000) @(negedge clk);
        for (int i = 0; i < N; i++) feed_en[i] = 1'b0;
        rand_mode = 1'b0;
        fixed_ready = '1;
        repeat (150) @(negedge clk);
        for (int f = 0; f < N * N; f++)
            check(expq[f].size() == 0, "R3", "words left undelivered", expq[f].size(), 0);
        check(out_valid == '0, "R3", "output idle after drain", longint'(out_valid), 0);

        finished = 1'b1;
        report();
        $finish;
    end
endmodule